// File: doc/BRIEF.md
# I2C Slave Transmitter with Clock Stretching

This block is the slave-transmit side of an I2C target. It filters the SCL and SDA lines through a short synchronizer and watches them for start and stop conditions. In the first frame after a start, it collects a 7-bit address and a read/write bit. When the address equals the programmed own address, it pulls SDA low on the ninth clock to acknowledge. If the master asked for a read, the block switches itself into transmit mode without any help from software.

The host side has four parts: a one-byte data register, a transmit-empty flag, an interrupt flag with an enable, and an acknowledge-status bit. A byte written to the data register moves into an internal shift register at the next byte boundary, which frees the data register for the byte after it. While no byte is waiting at a boundary, the block holds SCL low, so the master pauses until software supplies data.

Both bus lines are open-drain. The block only ever asserts a pull-low enable on each line.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, both pull-low enables, the interrupt request and every flag (busBusy, txMode, txEmpty, irqFlag, txReady, ackStatus) read 0.
- R2: SDA falling while SCL is high (start) sets busBusy. SDA rising while SCL is high (stop) clears busBusy, clears txMode and releases both lines.
- R3: The first frame after a start carries the address in bits 1 to 7, MSB first, and the read/write bit in bit 8, where 1 means read. On a match the block pulls SDA low through the ninth clock and sets irqFlag at that clock's rising edge. On a mismatch SDA stays released and irqFlag stays 0.
- R4: A matched address with the read bit at 1 sets txMode and txEmpty.
- R5: At a byte boundary in transmit mode, while txEmpty is 1, SCL is held low from the falling edge of the ninth clock until the host writes the data register.
- R6: A host write to the data register clears txEmpty. When the byte then moves into the shift register, txEmpty, irqFlag and txReady are set again.
- R7: Data bits leave MSB first. A 0 bit asserts the SDA pull-low and a 1 bit releases SDA. SDA changes only while SCL is low.
- R8: If the next byte was written while the previous one was being sent, SCL is released no later than 8 clock cycles after the master pulls SCL low for the ninth clock.
- R9: At the rising edge of the ninth clock after each data byte, ackStatus captures the SDA level (0 means acknowledged, 1 means not acknowledged) and irqFlag is set. After a not-acknowledge the block releases both lines and waits for a start or a stop.
- R10: A byte value of 0xFF keeps SDA released for all eight bit times. This is how the host ends a transfer.
- R11: irq equals irqFlag AND irqEn. An irqClr pulse clears irqFlag and txReady. If the hardware sets irqFlag in the same cycle as the pulse, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level as seen on the pad |
| sdaIn | input | 1 | SDA line level as seen on the pad |
| ownAddr | input | 7 | Slave address to respond to |
| irqEn | input | 1 | Lets irqFlag reach the irq output |
| dataWr | input | 1 | One-cycle strobe that writes dataIn to the data register |
| dataIn | input | 8 | Byte to transmit |
| irqClr | input | 1 | One-cycle strobe that clears irqFlag and txReady |
| sclOe | output | 1 | Pull-low enable for SCL (stretching) |
| sdaOe | output | 1 | Pull-low enable for SDA |
| irq | output | 1 | Interrupt request |
| irqFlag | output | 1 | Interrupt flag |
| txEmpty | output | 1 | Data register is free for the next byte |
| txReady | output | 1 | A byte has just entered the shift register |
| ackStatus | output | 1 | SDA level captured on the ninth clock of the last byte |
| busBusy | output | 1 | Bus is between a start and a stop |
| txMode | output | 1 | Block is in transmit mode |

## Verification
The address path is driven with two frames: one carrying a foreign address and one carrying the own address with the read bit set. Together they show that both the acknowledge and the mode switch depend on the compare. The transmit path sends three bytes:
- 0xA5 is written only after the bus has already been stretched, which exercises the hold-until-write path.
- 0x3C is written ahead of time, which exercises the double-buffered path with no long stretch.
- 0xFF must never assert the SDA pull-low.

The master acknowledges one byte and refuses another, so that ackStatus is seen to take both values. Running once with the interrupt enable low and once with it high separates the flag from the request line.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WAIT,
    ST_SETUP,
    ST_TX,
    ST_TACK
  } state_e;

  // Strobes and levels from the control to the datapath.
  typedef struct packed {
    logic addrShift;   // shift one address bit in
    logic matchAck;    // ninth-clock rise of a matched address
    logic loadShift;   // move data register into shift register
    logic dataShift;   // advance shift register by one bit
    logic ackCapture;  // ninth-clock rise of a data byte
    logic clrMode;     // start or stop seen
    logic sclHold;     // pull SCL low
    logic ackDrive;    // pull SDA low for address acknowledge
    logic txDrive;     // SDA follows the shift register MSB
  } ctl_t;

endpackage

// File: rtl/i2cs_dpath.sv
module i2cs_dpath
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              irqEn,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              irqClr,
  input  ctl_t              ctl,
  output logic              sclSync,
  output logic              sdaSync,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              addrMatch,
  output logic              addrRw,
  output logic              txEmpty,
  output logic              irqFlag,
  output logic              txReady,
  output logic              ackStatus,
  output logic              busBusy,
  output logic              txMode,
  output logic              irq,
  output logic              sclOe,
  output logic              sdaOe
);

  localparam int FRAME_W = ADDR_W + 1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclQ, sdaQ;
  logic [FRAME_W-1:0]     addrReg;
  logic [DATA_W-1:0]      dataReg, shiftReg;

  // Two-or-more flop synchronizers, idle-high reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclSync;
      sdaQ    <= sdaSync;
    end
  end

  assign sclSync  = sclPipe[SYNC_STAGES-1];
  assign sdaSync  = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclSync & ~sclQ;
  assign sclFall  = ~sclSync & sclQ;
  assign startDet = sclSync & sclQ & sdaQ & ~sdaSync;
  assign stopDet  = sclSync & sclQ & ~sdaQ & sdaSync;

  // Address frame capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= '0;
    else if (ctl.addrShift) addrReg <= {addrReg[FRAME_W-2:0], sdaSync};
  end

  assign addrMatch = (addrReg[FRAME_W-1:1] == ownAddr);
  assign addrRw    = addrReg[0];

  // Data register and shift register (double buffer).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (dataWr) dataReg <= dataIn;
      if (ctl.loadShift)      shiftReg <= dataReg;
      else if (ctl.dataShift) shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
    end
  end

  // Flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty   <= 1'b0;
      irqFlag   <= 1'b0;
      txReady   <= 1'b0;
      ackStatus <= 1'b0;
      busBusy   <= 1'b0;
      txMode    <= 1'b0;
    end else begin
      if (dataWr) txEmpty <= 1'b0;
      else if (ctl.loadShift || (ctl.matchAck && addrRw)) txEmpty <= 1'b1;

      if (ctl.matchAck || ctl.loadShift || ctl.ackCapture) irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;

      if (ctl.loadShift) txReady <= 1'b1;
      else if (irqClr)   txReady <= 1'b0;

      if (ctl.ackCapture) ackStatus <= sdaSync;

      if (startDet)     busBusy <= 1'b1;
      else if (stopDet) busBusy <= 1'b0;

      if (ctl.clrMode) txMode <= 1'b0;
      else if (ctl.matchAck && addrRw) txMode <= 1'b1;
    end
  end

  assign irq   = irqFlag & irqEn;
  assign sclOe = ctl.sclHold;
  assign sdaOe = ctl.ackDrive | (ctl.txDrive & ~shiftReg[DATA_W-1]);

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   startDet,
  input  logic   stopDet,
  input  logic   addrMatch,
  input  logic   addrRw,
  input  logic   txEmpty,
  input  logic   ackStatus,
  output ctl_t   ctl,
  output state_e state
);

  localparam int FRAME_W = ADDR_W + 1;
  localparam int MAX_W   = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
  localparam int CNT_W   = $clog2(MAX_W + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  state_e           stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    cntNext   = cnt;
    case (state)
      ST_IDLE: ;
      ST_ADDR: begin
        if (sclRise) begin
          ctl.addrShift = 1'b1;
          cntNext       = cnt + CNT_W'(1);
        end else if (sclFall && cnt == ADDR_LAST) begin
          stateNext = addrMatch ? ST_AACK : ST_IDLE;
        end
      end
      ST_AACK: begin
        ctl.ackDrive = 1'b1;
        if (sclRise)      ctl.matchAck = 1'b1;
        else if (sclFall) stateNext = addrRw ? ST_WAIT : ST_IDLE;
      end
      ST_WAIT: begin
        ctl.sclHold = 1'b1;
        if (!txEmpty) begin
          ctl.loadShift = 1'b1;
          stateNext     = ST_SETUP;
        end
      end
      ST_SETUP: begin
        ctl.sclHold = 1'b1;
        ctl.txDrive = 1'b1;
        cntNext     = '0;
        stateNext   = ST_TX;
      end
      ST_TX: begin
        ctl.txDrive = 1'b1;
        if (sclFall) begin
          if (cnt == DATA_LAST) begin
            stateNext = ST_TACK;
          end else begin
            ctl.dataShift = 1'b1;
            cntNext       = cnt + CNT_W'(1);
          end
        end
      end
      ST_TACK: begin
        if (sclRise)      ctl.ackCapture = 1'b1;
        else if (sclFall) stateNext = ackStatus ? ST_IDLE : ST_WAIT;
      end
      default: stateNext = ST_IDLE;
    endcase

    if (startDet) begin
      stateNext   = ST_ADDR;
      cntNext     = '0;
      ctl.clrMode = 1'b1;
    end else if (stopDet) begin
      stateNext   = ST_IDLE;
      ctl.clrMode = 1'b1;
    end
  end

endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-2:0] ownAddr,
  input  logic              irqEn,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              irqClr,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              irq,
  output logic              irqFlag,
  output logic              txEmpty,
  output logic              txReady,
  output logic              ackStatus,
  output logic              busBusy,
  output logic              txMode
);

  localparam int ADDR_W = DATA_W - 1;

  ctl_t   ctl;
  state_e state;
  logic   sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic   addrMatch, addrRw;

  i2cs_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet),
    .addrMatch(addrMatch), .addrRw(addrRw),
    .txEmpty(txEmpty), .ackStatus(ackStatus),
    .ctl(ctl), .state(state)
  );

  i2cs_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN),
    .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .irqEn(irqEn),
    .dataWr(dataWr), .dataIn(dataIn), .irqClr(irqClr),
    .ctl(ctl),
    .sclSync(sclSync), .sdaSync(sdaSync),
    .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet),
    .addrMatch(addrMatch), .addrRw(addrRw),
    .txEmpty(txEmpty), .irqFlag(irqFlag), .txReady(txReady),
    .ackStatus(ackStatus), .busBusy(busBusy), .txMode(txMode),
    .irq(irq), .sclOe(sclOe), .sdaOe(sdaOe)
  );

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   sclSync,
  input logic   sdaSync,
  input logic   startDet,
  input logic   stopDet,
  input logic   dataWr,
  input logic   irqClr,
  input ctl_t   ctl,
  input state_e state,
  input logic   txEmpty,
  input logic   irqFlag,
  input logic   txReady,
  input logic   ackStatus,
  input logic   busBusy,
  input logic   sclOe,
  input logic   sdaOe
);

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> busBusy);

  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!busBusy && !sclOe && !sdaOe));

  a_r5_hold_while_empty: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && txEmpty && !dataWr && !startDet && !stopDet) |=> sclOe);

  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> !txEmpty);

  a_r6_load_refills: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadShift && !dataWr) |=> (txEmpty && irqFlag && txReady));

  a_r7_sda_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclSync && $past(sclSync) && !$past(startDet) && !$past(stopDet)) |-> $stable(sdaOe));

  a_r9_ack_capture: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ackCapture |=> (ackStatus == $past(sdaSync) && irqFlag));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !ctl.matchAck && !ctl.loadShift && !ctl.ackCapture) |=> (!irqFlag && !txReady));

endmodule

bind i2c_slave_tx i2cs_checker u_checker (
  .clk(clk), .rstN(rstN),
  .sclSync(sclSync), .sdaSync(sdaSync),
  .startDet(startDet), .stopDet(stopDet),
  .dataWr(dataWr), .irqClr(irqClr),
  .ctl(ctl), .state(state),
  .txEmpty(txEmpty), .irqFlag(irqFlag), .txReady(txReady),
  .ackStatus(ackStatus), .busBusy(busBusy),
  .sclOe(sclOe), .sdaOe(sdaOe)
);

// File: tb/test_i2c_slave_tx.sv
`timescale 1ns/1ps
module test_i2c_slave_tx;

  localparam int H = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       irqEn = 1'b0, dataWr = 1'b0, irqClr = 1'b0;
  logic [7:0] dataIn = '0;
  logic       sclOe, sdaOe, irq, irqFlag, txEmpty, txReady, ackStatus, busBusy, txMode;
  logic       sclLine, sdaLine;
  int         nRun = 0, nFail = 0;
  bit         done = 1'b0;

  assign sclLine = sclM & ~sclOe;
  assign sdaLine = sdaM & ~sdaOe;

  i2c_slave_tx i_i2c_slave_tx (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .ownAddr(OWN), .irqEn(irqEn), .dataWr(dataWr), .dataIn(dataIn), .irqClr(irqClr),
    .sclOe(sclOe), .sdaOe(sdaOe), .irq(irq), .irqFlag(irqFlag), .txEmpty(txEmpty),
    .txReady(txReady), .ackStatus(ackStatus), .busBusy(busBusy), .txMode(txMode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitCycle(input logic b, output logic s, output logic oe);
    sdaM = b;
    tick(H);
    sclM = 1'b1;
    tick(1);
    while (!sclLine) tick(1);
    tick(H);
    s  = sdaLine;
    oe = sdaOe;
    sclM = 1'b0;
    tick(1);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; tick(H);
    sdaM = 1'b0; tick(H);
    sclM = 1'b0; tick(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(H);
    sclM = 1'b1; tick(H);
    sdaM = 1'b1; tick(H);
  endtask

  task automatic sendAddr(input logic [6:0] a, input logic rw, output logic acked);
    logic [7:0] frame = {a, rw};
    logic s, oe;
    for (int i = 7; i >= 0; i--) bitCycle(frame[i], s, oe);
    bitCycle(1'b1, s, oe);
    acked = ~s;
  endtask

  task automatic readByte(input logic ackBit, output logic [7:0] d, output logic [7:0] oeMask);
    logic s, oe;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s, oe);
      d[i] = s;
      oeMask[i] = oe;
    end
    bitCycle(ackBit, s, oe);
  endtask

  task automatic cpuWrite(input logic [7:0] b);
    dataIn = b; dataWr = 1'b1; tick(1); dataWr = 1'b0;
  endtask

  task automatic cpuClr();
    irqClr = 1'b1; tick(1); irqClr = 1'b0;
  endtask

  task automatic testReset();
    check("R1 sclOe", sclOe, 0);
    check("R1 sdaOe", sdaOe, 0);
    check("R1 irq", irq, 0);
    check("R1 flags", {busBusy, txMode, txEmpty, irqFlag, txReady, ackStatus}, 0);
  endtask

  task automatic testMismatch();
    logic acked;
    busStart();
    check("R2 busBusy after start", busBusy, 1);
    sendAddr(OWN ^ 7'h01, 1'b1, acked);
    check("R3 no ack on mismatch", acked, 0);
    tick(H);
    check("R3 no irqFlag on mismatch", irqFlag, 0);
    check("R3 no txMode on mismatch", txMode, 0);
    check("R3 SCL free on mismatch", sclOe, 0);
    busStop();
    check("R2 busBusy after stop", busBusy, 0);
  endtask

  task automatic testRead();
    logic acked;
    logic [7:0] d, m;
    irqEn = 1'b1;
    busStart();
    sendAddr(OWN, 1'b1, acked);
    check("R3 address acknowledged", acked, 1);
    check("R3 irqFlag on match", irqFlag, 1);
    check("R4 txMode set", txMode, 1);
    check("R4 txEmpty set", txEmpty, 1);
    check("R11 irq with enable", irq, 1);
    tick(50);
    check("R5 SCL held while empty", sclOe, 1);
    check("R5 SDA released while held", sdaOe, 0);
    cpuClr();
    check("R11 irqClr clears flag", irqFlag, 0);
    check("R11 irq drops", irq, 0);
    cpuWrite(8'hA5);
    check("R6 write clears txEmpty", txEmpty, 0);
    tick(4);
    check("R6 txEmpty set after load", txEmpty, 1);
    check("R6 irqFlag set after load", irqFlag, 1);
    check("R6 txReady set after load", txReady, 1);
    check("R5 SCL released after write", sclOe, 0);
    cpuClr();
    check("R11 irqClr clears txReady", txReady, 0);
    cpuWrite(8'h3C);
    readByte(1'b0, d, m);
    check("R7 first byte MSB first", d, 8'hA5);
    check("R7 pull-low only on 0 bits", m, 8'h5A);
    check("R9 ackStatus on ACK", ackStatus, 0);
    check("R9 irqFlag at ninth clock", irqFlag, 1);
    tick(7);
    check("R8 no long stretch when buffered", sclOe, 0);
    readByte(1'b1, d, m);
    check("R7 second byte", d, 8'h3C);
    check("R9 ackStatus on NACK", ackStatus, 1);
    tick(H);
    check("R9 lines released after NACK", {sclOe, sdaOe}, 0);
    busStop();
    check("R2 stop clears busBusy", busBusy, 0);
    check("R2 stop clears txMode", txMode, 0);
  endtask

  task automatic testFinalFF();
    logic acked;
    logic [7:0] d, m;
    irqEn = 1'b0;
    cpuClr();
    busStart();
    sendAddr(OWN, 1'b1, acked);
    check("R3 second match acked", acked, 1);
    check("R11 flag set with enable off", irqFlag, 1);
    check("R11 irq masked", irq, 0);
    cpuWrite(8'hFF);
    tick(4);
    readByte(1'b1, d, m);
    check("R10 0xFF read back", d, 8'hFF);
    check("R10 SDA never pulled for 0xFF", m, 8'h00);
    busStop();
    check("R2 idle after final stop", busBusy, 0);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    testReset();
    testMismatch();
    testRead();
    testFinalFF();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule